// File: doc/BRIEF.md
# Pipelined Burst SRAM with Zero Bus Turnaround

This block is a synchronous, pipelined static memory with a small on-chip array. Each accepted cycle can start or continue an access, and reads and writes may follow each other on consecutive cycles with no idle slot on the data bus. Read data comes from an output register two clock edges after its address is taken. Write data is taken two edges after its address. The bus timing is therefore the same for both directions.

An access begins with a load cycle. The access type and the base address are captured at that cycle. Later advance cycles step a two-bit counter through the low address bits in linear order. Because writes wait two cycles for their data, a read can arrive while an older write to the same word is still pending. Coherency logic merges the pending bytes into the read result. A clock enable freezes the whole pipeline. A sleep input, synchronized over two edges, stops new accesses from being serviced.

Top module: `pipe_burst_sram`

## Requirements
- R1: A read taken at active edge k drives its word on `rdata` after active edge k+2. For a write taken at active edge k, `wdata` is sampled at active edge k+2.
- R2: A load cycle (`adv_ld`=0, `cke_n`=0) with the chip selected (`ce_n`=0 and `ce`=1) and the block awake starts a new burst at `addr`. The burst writes when `we_n`=0 and reads when `we_n`=1.
- R3: An advance cycle (`adv_ld`=1, `cke_n`=0) steps the burst counter whatever `ce_n`, `ce` and `we_n` are. The access type of the running burst stays the one taken at its load cycle.
- R4: The burst walks the two low address bits as base+0, +1, +2, +3 modulo 4, and the upper address bits stay fixed (a base of 01 gives 01, 10, 11, 00).
- R5: During a write, byte lane i (bits 8i+7..8i) is written only when `bw_n[i]`=0. Byte enables are taken on each cycle of the burst, and `bw_n` all ones writes nothing.
- R6: A read taken one cycle after a write to the same word returns the bytes of that write merged with the stored bytes of the other lanes. In general every read returns the newest data.
- R7: While `cke_n`=1, no access is started or advanced, no write is committed and the outputs hold.
- R8: `rdata_en` is 1 only while a read result is held and `oe_n`=0. Whenever `rdata_en` is 0, `rdata` is zero.
- R9: A load cycle with the chip deselected ends the burst. Advance cycles after it start no access until the next selected load.
- R10: Once `sleep` has been 1 at two consecutive edges, accesses at later edges are ignored and the running burst ends. After `sleep` has been low for two edges, a new load is serviced again.
- R11: After reset, `rdata_en` is 0 and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable; high freezes everything |
| adv_ld | input | 1 | 0 = load new address, 1 = advance burst counter |
| we_n | input | 1 | Active-low write select, taken on load cycles |
| bw_n | input | NB | Active-low byte write enables, one per lane |
| ce_n | input | 1 | Active-low chip enable |
| ce | input | 1 | Active-high chip enable |
| oe_n | input | 1 | Active-low output enable |
| sleep | input | 1 | Low-power request, synchronized over two edges |
| addr | input | AW | Word address |
| wdata | input | NB*BW | Write data, sampled two edges after its address |
| rdata | output | NB*BW | Read data, zero when not driven |
| rdata_en | output | 1 | Read data driver enable |

## Verification
The checks that run every cycle cover the following. The burst counter steps on every advance cycle and clears on every load. The access type cannot change inside a burst. A clock-enable stall freezes the counter, the burst state and the output register. A pending read always produces a result two active edges later. No access enters the pipeline while the synchronized sleep state is set. Only the bench's scenarios can show the data itself, because the data depends on the whole history of the array. These scenarios are: the linear order from odd base addresses, partial and empty byte writes, forwarding from a write one cycle ahead, writes whose data arrives after a stall, deselected and sleeping periods, and output-enable gating. All of these are compared against a reference memory.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_e;

    localparam int unsigned BURST_BITS = 2;
endpackage

// File: rtl/pbs_burst_ctl.sv
module pbs_burst_ctl
    import pbs_pkg::*;
#(
    parameter int unsigned AW = 6,
    parameter int unsigned NB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cke_n,
    input  logic          adv_ld,
    input  logic          we_n,
    input  logic [NB-1:0] bw_n,
    input  logic          ce_n,
    input  logic          ce,
    input  logic          sleep,
    input  logic [AW-1:0] addr,
    output logic          iss_vld,
    output logic          iss_wr,
    output logic [AW-1:0] iss_addr,
    output logic [NB-1:0] iss_mask,
    output logic          asleep
);
    localparam int unsigned CB = BURST_BITS;

    typedef struct packed {
        logic [AW-1:0] base;
        logic [CB-1:0] cnt;
        logic          active;
        acc_e          kind;
        logic          slp1;
        logic          slp2;
    } ctl_t;

    ctl_t cur_q, nxt_d;
    logic selected;
    logic [CB-1:0] step_lo;

    assign selected = ~ce_n & ce;
    assign asleep   = cur_q.slp2;

    always_comb begin
        nxt_d    = cur_q;
        step_lo  = cur_q.base[CB-1:0] + cur_q.cnt + CB'(1);
        iss_mask = ~bw_n;
        if (!adv_ld) begin
            iss_vld  = selected & ~cur_q.slp2;
            iss_wr   = ~we_n;
            iss_addr = addr;
        end else begin
            iss_vld  = cur_q.active & ~cur_q.slp2;
            iss_wr   = (cur_q.kind == ACC_WRITE);
            iss_addr = {cur_q.base[AW-1:CB], step_lo};
        end
        if (!cke_n) begin
            if (!adv_ld) begin
                nxt_d.base   = addr;
                nxt_d.cnt    = '0;
                nxt_d.active = selected & ~cur_q.slp2;
                nxt_d.kind   = we_n ? ACC_READ : ACC_WRITE;
            end else begin
                nxt_d.cnt = cur_q.cnt + CB'(1);
                if (cur_q.slp2) begin
                    nxt_d.active = 1'b0;
                end
            end
        end
        nxt_d.slp1 = sleep;
        nxt_d.slp2 = cur_q.slp1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{base: '0, cnt: '0, active: 1'b0, kind: ACC_READ,
                       slp1: 1'b0, slp2: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv_ld) |=> (cur_q.cnt == CB'($past(cur_q.cnt) + CB'(1))));

    // R2
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld) |=> (cur_q.cnt == '0));

    // R3
    kind_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv_ld) |=> $stable(cur_q.kind));

    // R7
    ctl_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(cur_q.cnt) && $stable(cur_q.base) && $stable(cur_q.active)));
endmodule

// File: rtl/pbs_store.sv
module pbs_store #(
    parameter int unsigned AW = 6,
    parameter int unsigned NB = 4,
    parameter int unsigned BW = 8
) (
    input  logic             clk,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [NB*BW-1:0] wr_data,
    input  logic [NB-1:0]    wr_mask,
    output logic [NB*BW-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << AW;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [BW-1:0] lane_mem [DEPTH];
        logic [BW-1:0] lane_rd_q;

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[g]) begin
                lane_mem[wr_addr] <= wr_data[g*BW +: BW];
            end
            if (rd_en) begin
                lane_rd_q <= lane_mem[rd_addr];
            end
        end

        assign rd_data[g*BW +: BW] = lane_rd_q;
    end
endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
    import pbs_pkg::*;
#(
    parameter int unsigned AW = 6,
    parameter int unsigned NB = 4,
    parameter int unsigned BW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke_n,
    input  logic             adv_ld,
    input  logic             we_n,
    input  logic [NB-1:0]    bw_n,
    input  logic             ce_n,
    input  logic             ce,
    input  logic             oe_n,
    input  logic             sleep,
    input  logic [AW-1:0]    addr,
    input  logic [NB*BW-1:0] wdata,
    output logic [NB*BW-1:0] rdata,
    output logic             rdata_en
);
    localparam int unsigned DW = NB * BW;

    typedef struct packed {
        logic          vld;
        logic          wr;
        logic [AW-1:0] addr;
        logic [NB-1:0] mask;
    } op_t;

    typedef struct packed {
        op_t           s1;
        op_t           s2;
        logic [DW-1:0] fwd_data;
        logic [NB-1:0] fwd_mask;
        logic          out_vld;
        logic [DW-1:0] out;
    } pipe_t;

    function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                                 input logic [DW-1:0] new_w,
                                                 input logic [NB-1:0] sel);
        logic [DW-1:0] res;
        res = old_w;
        for (int i = 0; i < NB; i++) begin
            if (sel[i]) res[i*BW +: BW] = new_w[i*BW +: BW];
        end
        return res;
    endfunction

    logic          iss_vld, iss_wr, asleep;
    logic [AW-1:0] iss_addr;
    logic [NB-1:0] iss_mask;
    logic [DW-1:0] arr_rd;
    logic          raw_hit;
    pipe_t         cur_q, nxt_d;

    pbs_burst_ctl #(.AW(AW), .NB(NB)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cke_n    (cke_n),
        .adv_ld   (adv_ld),
        .we_n     (we_n),
        .bw_n     (bw_n),
        .ce_n     (ce_n),
        .ce       (ce),
        .sleep    (sleep),
        .addr     (addr),
        .iss_vld  (iss_vld),
        .iss_wr   (iss_wr),
        .iss_addr (iss_addr),
        .iss_mask (iss_mask),
        .asleep   (asleep)
    );

    pbs_store #(.AW(AW), .NB(NB), .BW(BW)) u_store (
        .clk     (clk),
        .rd_en   (~cke_n),
        .rd_addr (cur_q.s1.addr),
        .wr_en   (~cke_n & cur_q.s2.vld & cur_q.s2.wr),
        .wr_addr (cur_q.s2.addr),
        .wr_data (wdata),
        .wr_mask (cur_q.s2.mask),
        .rd_data (arr_rd)
    );

    assign raw_hit = cur_q.s1.vld & ~cur_q.s1.wr & cur_q.s2.vld & cur_q.s2.wr
                   & (cur_q.s1.addr == cur_q.s2.addr);

    always_comb begin
        nxt_d = cur_q;
        if (!cke_n) begin
            nxt_d.s1.vld  = iss_vld;
            nxt_d.s1.wr   = iss_wr;
            nxt_d.s1.addr = iss_addr;
            nxt_d.s1.mask = iss_mask;
            nxt_d.s2      = cur_q.s1;
            nxt_d.fwd_mask = raw_hit ? cur_q.s2.mask : '0;
            nxt_d.fwd_data = wdata;
            nxt_d.out_vld  = cur_q.s2.vld & ~cur_q.s2.wr;
            if (cur_q.s2.vld && !cur_q.s2.wr) begin
                nxt_d.out = lane_merge(arr_rd, cur_q.fwd_data, cur_q.fwd_mask);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rdata_en = cur_q.out_vld & ~oe_n;
    assign rdata    = rdata_en ? cur_q.out : '0;

    // R1
    read_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && cur_q.s2.vld && !cur_q.s2.wr) |=> cur_q.out_vld);

    // R7
    pipe_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(cur_q.out) && $stable(cur_q.out_vld) && $stable(cur_q.s1)
                   && $stable(cur_q.s2)));

    // R10
    sleep_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && asleep) |=> !cur_q.s1.vld);
endmodule

// File: tb/pipe_burst_sram_bench.sv
module pipe_burst_sram_bench;
    localparam int unsigned AW = 6;
    localparam int unsigned NB = 4;
    localparam int unsigned BW = 8;
    localparam int unsigned DW = NB * BW;
    localparam int unsigned DEPTH = 1 << AW;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cke_n = 1'b1, adv_ld = 1'b0, we_n = 1'b1, ce_n = 1'b1, ce = 1'b1;
    logic oe_n = 1'b0, sleep = 1'b0;
    logic [NB-1:0] bw_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic rdata_en;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    pipe_burst_sram #(.AW(AW), .NB(NB), .BW(BW)) u_pipe_burst_sram (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv_ld(adv_ld), .we_n(we_n),
        .bw_n(bw_n), .ce_n(ce_n), .ce(ce), .oe_n(oe_n), .sleep(sleep),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // reference model state
    logic [DW-1:0] ref_mem [DEPTH];
    bit m_act, m_wr, m_s1, m_s2;
    logic [AW-1:0] m_base;
    logic [1:0] m_cnt;
    bit p1_v, p1_w, p2_v, p2_w;
    logic [AW-1:0] p1_a, p2_a;
    logic [NB-1:0] p1_m, p2_m;
    bit exp_v;
    logic [DW-1:0] exp_d;

    function automatic logic [DW-1:0] merge_w(input logic [DW-1:0] o,
                                              input logic [DW-1:0] n,
                                              input logic [NB-1:0] m);
        logic [DW-1:0] r = o;
        for (int i = 0; i < NB; i++) if (m[i]) r[i*BW +: BW] = n[i*BW +: BW];
        return r;
    endfunction

    function automatic logic [AW-1:0] burst_addr(input logic [AW-1:0] b,
                                                 input logic [1:0] c);
        logic [1:0] lo = b[1:0] + c + 2'd1;
        return {b[AW-1:2], lo};
    endfunction

    task automatic check(input bit cond, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] expv);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic cyc(input bit ckn, input bit adv, input bit wen,
                       input logic [NB-1:0] bwn, input bit cen, input bit ceh,
                       input bit oen, input bit slp, input logic [AW-1:0] a,
                       input string tag);
        bit n_v, n_w, exp_en;
        logic [AW-1:0] n_a;
        logic [DW-1:0] wd = DW'($urandom);
        cke_n = ckn; adv_ld = adv; we_n = wen; bw_n = bwn; ce_n = cen; ce = ceh;
        oe_n = oen; sleep = slp; addr = a; wdata = wd;
        if (!ckn) begin
            if (p2_v && p2_w) begin
                ref_mem[p2_a] = merge_w(ref_mem[p2_a], wd, p2_m);
                exp_v = 1'b0;
            end else if (p2_v) begin
                exp_v = 1'b1;
                exp_d = ref_mem[p2_a];
            end else begin
                exp_v = 1'b0;
            end
            if (!adv) begin
                n_v = !cen && ceh && !m_s2;
                n_w = !wen;
                n_a = a;
                m_base = a; m_cnt = 2'd0; m_act = n_v; m_wr = !wen;
            end else begin
                n_v = m_act && !m_s2;
                n_w = m_wr;
                n_a = burst_addr(m_base, m_cnt);
                m_cnt = m_cnt + 2'd1;
                if (m_s2) m_act = 1'b0;
            end
            p2_v = p1_v; p2_w = p1_w; p2_a = p1_a; p2_m = p1_m;
            p1_v = n_v; p1_w = n_w; p1_a = n_a; p1_m = ~bwn;
        end
        m_s2 = m_s1; m_s1 = slp;
        @(posedge clk);
        @(negedge clk);
        exp_en = exp_v && !oen;
        check(rdata_en === exp_en, {tag, " enable"}, DW'(rdata_en), DW'(exp_en));
        if (exp_en) check(rdata === exp_d, {tag, " data"}, rdata, exp_d);
        else        check(rdata === '0, {tag, " idle zero"}, rdata, '0);
    endtask

    // convenience wrappers
    task automatic ld(input bit wen, input logic [NB-1:0] bwn, input logic [AW-1:0] a,
                      input string tag);
        cyc(1'b0, 1'b0, wen, bwn, 1'b0, 1'b1, 1'b0, 1'b0, a, tag);
    endtask

    task automatic adv(input logic [NB-1:0] bwn, input string tag);
        cyc(1'b0, 1'b1, 1'b1, bwn, 1'b0, 1'b1, 1'b0, 1'b0, '0, tag);
    endtask

    task automatic desel(input string tag);
        cyc(1'b0, 1'b0, 1'b1, '1, 1'b1, 1'b1, 1'b0, 1'b0, '0, tag);
    endtask

    initial begin
        m_act = 0; m_wr = 0; m_s1 = 0; m_s2 = 0; m_base = '0; m_cnt = '0;
        p1_v = 0; p2_v = 0; p1_w = 0; p2_w = 0; p1_a = '0; p2_a = '0;
        p1_m = '0; p2_m = '0; exp_v = 0; exp_d = '0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(rdata_en === 1'b0, "R11 enable", DW'(rdata_en), '0);
        check(rdata === '0, "R11 data", rdata, '0);

        // R2: fill whole array with full-word write bursts
        for (int b = 0; b < int'(DEPTH) / 4; b++) begin
            ld(1'b0, '0, AW'(b * 4), "R2");
            for (int k = 0; k < 3; k++) adv('0, "R2");
        end
        desel("R9"); desel("R9");

        // R4: read burst from odd base, wraps within the group of four
        ld(1'b1, '1, AW'(5), "R4");
        for (int k = 0; k < 3; k++) adv('1, "R4");
        desel("R1"); desel("R1");

        // R5: partial byte write burst, then empty write, then read back
        ld(1'b0, 4'b1010, AW'(14), "R5");
        adv(4'b0101, "R5");
        adv(4'b1111, "R5");
        adv(4'b0110, "R5");
        ld(1'b1, '1, AW'(14), "R5");
        for (int k = 0; k < 3; k++) adv('1, "R5");
        desel("R5"); desel("R5");

        // R3: advance cycles with chip deselected and write select toggled keep a read burst
        ld(1'b1, '1, AW'(20), "R3");
        cyc(1'b0, 1'b1, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R3");
        cyc(1'b0, 1'b1, 1'b0, '0, 1'b1, 1'b1, 1'b0, 1'b0, '0, "R3");
        adv('1, "R3");
        desel("R3"); desel("R3");

        // R6: write then immediate read of same word, partial lanes
        ld(1'b0, 4'b1100, AW'(9), "R6");
        ld(1'b1, '1, AW'(9), "R6");
        ld(1'b0, 4'b0011, AW'(9), "R6");
        ld(1'b0, 4'b1001, AW'(9), "R6");
        ld(1'b1, '1, AW'(9), "R6");
        ld(1'b1, '1, AW'(9), "R6");
        desel("R6"); desel("R6");

        // R7: stalls in the middle of a write and of a read
        ld(1'b0, 4'b0000, AW'(30), "R7");
        cyc(1'b1, 1'b0, 1'b1, '1, 1'b1, 1'b1, 1'b0, 1'b0, AW'(3), "R7");
        cyc(1'b1, 1'b1, 1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, AW'(3), "R7");
        ld(1'b1, '1, AW'(30), "R7");
        desel("R7");
        cyc(1'b1, 1'b0, 1'b1, '1, 1'b1, 1'b1, 1'b0, 1'b0, '0, "R7");
        cyc(1'b1, 1'b0, 1'b1, '1, 1'b1, 1'b1, 1'b0, 1'b0, '0, "R7");
        desel("R7"); desel("R7");

        // R8: output enable off during a read result
        ld(1'b1, '1, AW'(33), "R8");
        adv('1, "R8");
        cyc(1'b0, 1'b0, 1'b1, '1, 1'b1, 1'b1, 1'b1, 1'b0, '0, "R8");
        cyc(1'b0, 1'b0, 1'b1, '1, 1'b1, 1'b1, 1'b1, 1'b0, '0, "R8");
        desel("R8");

        // R9: deselect then advance with writes requested: nothing written
        cyc(1'b0, 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b0, 1'b0, AW'(40), "R9");
        for (int k = 0; k < 4; k++) adv('0, "R9");
        ld(1'b1, '1, AW'(40), "R9");
        for (int k = 0; k < 3; k++) adv('1, "R9");
        desel("R9"); desel("R9");

        // R10: sleep blocks a write burst, then wake and reload
        for (int k = 0; k < 2; k++)
            cyc(1'b0, 1'b0, 1'b1, '1, 1'b1, 1'b1, 1'b0, 1'b1, '0, "R10");
        cyc(1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b1, AW'(44), "R10");
        for (int k = 0; k < 3; k++)
            cyc(1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b1, '0, "R10");
        for (int k = 0; k < 2; k++)
            cyc(1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R10");
        ld(1'b1, '1, AW'(44), "R10");
        for (int k = 0; k < 3; k++) adv('1, "R10");
        desel("R10"); desel("R10");

        // random mix over a narrow address window
        begin
            bit slp = 1'b0;
            for (int n = 0; n < 3000; n++) begin
                if ($urandom_range(99) == 0) slp = ~slp;
                cyc(($urandom_range(99) < 12), ($urandom_range(99) < 55),
                    bit'($urandom_range(1)), NB'($urandom),
                    ($urandom_range(99) < 10), ($urandom_range(99) > 5),
                    ($urandom_range(99) < 8), slp,
                    AW'($urandom_range(11)), "R1/R6");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule